// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a general-purpose I/O port of up to 32 pins behind a plain 32-bit register bus. The bus has a byte address, a write strobe with write data, and a read strobe with combinational read data. Software uses it to set the output value and the output enable of each pad. It can also read the synchronized pad levels and arm each pin as an interrupt source.

Every pin has its own trigger detector with four selectable conditions: level low, level high, rising edge or falling edge. Events land in a sticky status register, where each bit is cleared by writing a one to it. A mask register decides which status bits become pending. Pending pins 0–15 drive one request line and pins 16 and up drive a second; a third line combines all of them. A system can therefore route the two halves to separate controller inputs or use the single combined request.

Top module: `gpio_irq_port`

## Requirements
- R1: The output value register (offset 0x00) drives `pin_out` and the direction register (offset 0x04) drives `pin_oe`, one bit per pin. A 1 in the direction register enables the pad driver. Both read back what was written.
- R2: Offset 0x08 is read-only and returns `pin_in` after a two-stage synchronizer. A change on `pin_in` in one cycle is visible in reads two cycles later. Writes to 0x08 have no effect.
- R3: The trigger code for pin n is the 2-bit field at bits [2·(n mod 16)+1 : 2·(n mod 16)]. For pins 0–15 the field is in the config-low register (0x0C) and for pins 16–31 it is in the config-high register (0x10). Both registers read back.
- R4: Code 0 sets the pin's status bit on every cycle in which the synchronized level is 0. Code 1 does the same while the level is 1.
- R5: Code 2 sets the status bit when the synchronized level is 1 and was 0 one cycle earlier (rising edge). Code 3 sets it on the opposite transition (falling edge).
- R6: The status register is at 0x18. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged. If a detector event and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: The mask register is at 0x14, and a pin is pending when both its status bit and its mask bit are 1. `irq_lo` is the OR of pending pins 0–15, `irq_hi` is the OR of pending pins 16–31, and `irq_any` is the OR of all pending pins.
- R8: After reset, the output value, direction, mask, config and status registers are all zero. Reads of any offset other than the seven listed return zero, and writes to such offsets change nothing.
- R9: `bus_rdata` is zero in every cycle in which `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| pin_in | input | PINS | Pad input levels, asynchronous |
| pin_out | output | PINS | Output value to the pad drivers |
| pin_oe | output | PINS | Output enable to the pad drivers |
| irq_lo | output | 1 | Request for pending pins 0–15 |
| irq_hi | output | 1 | Request for pending pins 16 and up |
| irq_any | output | 1 | Request for any pending pin |

## Verification
Several properties are checked on every cycle. A detector event always leaves its status bit set in the next cycle, even when a clear hits the same bit. A write-one-to-clear removes exactly the bits that saw no event. The combined request always equals the OR of the two half requests, and a zero mask never lets a request out. Writes to unmapped offsets leave every register stable, the edge reference always lags the synchronized level by one cycle, and idle reads return zero. Other behaviour needs the bench's scenarios, which follow pin activity over many cycles: the two-cycle delay through the synchronizer, the trigger field position in the two config registers, level re-triggering after a clear, the edge polarity in each mode, and which pins feed each half request.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // Byte offsets of the register map (decoded by the bus)
   localparam logic [4:0] OFS_DATA  = 5'h00;
   localparam logic [4:0] OFS_DIR   = 5'h04;
   localparam logic [4:0] OFS_PAD   = 5'h08;
   localparam logic [4:0] OFS_CFGLO = 5'h0C;
   localparam logic [4:0] OFS_CFGHI = 5'h10;
   localparam logic [4:0] OFS_MASK  = 5'h14;
   localparam logic [4:0] OFS_STAT  = 5'h18;

   localparam int unsigned BUS_W       = 32;
   localparam int unsigned HALF_PINS   = 16;
   localparam int unsigned TRIG_W      = 2;

   typedef enum logic [1:0] {
      TRIG_LVL_LO = 2'd0,
      TRIG_LVL_HI = 2'd1,
      TRIG_RISE   = 2'd2,
      TRIG_FALL   = 2'd3
   } trig_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_async;
         for (int s = 1; s < int'(STAGES); s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_irq_pkg::*;
#(
   parameter int unsigned PINS = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [PINS-1:0]              lvl,
   input  logic [PINS-1:0][TRIG_W-1:0]  mode,
   output logic [PINS-1:0]              hit
);

   logic [PINS-1:0] lvl_d;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_d <= '0;
      else        lvl_d <= lvl;
   end

   for (genvar n = 0; n < PINS; n++) begin : g_pin
      always_comb begin
         unique case (trig_e'(mode[n]))
            TRIG_LVL_LO: hit[n] = ~lvl[n];
            TRIG_LVL_HI: hit[n] =  lvl[n];
            TRIG_RISE:   hit[n] =  lvl[n] & ~lvl_d[n];
            TRIG_FALL:   hit[n] = ~lvl[n] &  lvl_d[n];
            default:     hit[n] = 1'b0;
         endcase
      end
   end

   // R5
   edge_ref_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_d == $past(lvl));

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned PINS   = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic                         bus_wr,
   input  logic [BUS_W-1:0]             bus_wdata,
   input  logic                         bus_rd,
   output logic [BUS_W-1:0]             bus_rdata,
   input  logic [PINS-1:0]              pad,
   input  logic [PINS-1:0]              hit,
   output logic [PINS-1:0][TRIG_W-1:0]  mode,
   output logic [PINS-1:0]              dout,
   output logic [PINS-1:0]              dir,
   output logic [PINS-1:0]              mask,
   output logic [PINS-1:0]              status
);

   logic sel_data, sel_dir, sel_pad, sel_lo, sel_hi, sel_mask, sel_stat, mapped;
   logic [PINS-1:0]  clr;
   logic [BUS_W-1:0] cfg_lo_img, cfg_hi_img;

   assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));
   assign sel_dir  = (bus_addr == ADDR_W'(OFS_DIR));
   assign sel_pad  = (bus_addr == ADDR_W'(OFS_PAD));
   assign sel_lo   = (bus_addr == ADDR_W'(OFS_CFGLO));
   assign sel_hi   = (bus_addr == ADDR_W'(OFS_CFGHI));
   assign sel_mask = (bus_addr == ADDR_W'(OFS_MASK));
   assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
   assign mapped   = sel_data | sel_dir | sel_pad | sel_lo | sel_hi | sel_mask | sel_stat;

   // plain read/write registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout <= '0;
         dir  <= '0;
         mask <= '0;
      end else if (bus_wr) begin
         if (sel_data) dout <= bus_wdata[PINS-1:0];
         if (sel_dir)  dir  <= bus_wdata[PINS-1:0];
         if (sel_mask) mask <= bus_wdata[PINS-1:0];
      end
   end

   // trigger fields: pin n lives in half n/16 at bit 2*(n mod 16)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= '0;
      end else if (bus_wr) begin
         for (int n = 0; n < int'(PINS); n++) begin
            if ((n < int'(HALF_PINS)) ? sel_lo : sel_hi)
               mode[n] <= bus_wdata[TRIG_W*(n % int'(HALF_PINS)) +: TRIG_W];
         end
      end
   end

   always_comb begin
      cfg_lo_img = '0;
      cfg_hi_img = '0;
      for (int n = 0; n < int'(PINS); n++) begin
         if (n < int'(HALF_PINS))
            cfg_lo_img[TRIG_W*(n % int'(HALF_PINS)) +: TRIG_W] = mode[n];
         else
            cfg_hi_img[TRIG_W*(n % int'(HALF_PINS)) +: TRIG_W] = mode[n];
      end
   end

   // sticky status, write-one-to-clear, detector event has priority
   assign clr = (bus_wr && sel_stat) ? bus_wdata[PINS-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr) | hit;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_data)      bus_rdata[PINS-1:0] = dout;
         else if (sel_dir)  bus_rdata[PINS-1:0] = dir;
         else if (sel_pad)  bus_rdata[PINS-1:0] = pad;
         else if (sel_lo)   bus_rdata           = cfg_lo_img;
         else if (sel_hi)   bus_rdata           = cfg_hi_img;
         else if (sel_mask) bus_rdata[PINS-1:0] = mask;
         else if (sel_stat) bus_rdata[PINS-1:0] = status;
      end
   end

   // R6
   event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((status & $past(hit)) == $past(hit)));

   // R6
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_stat) |=> ((status & $past(bus_wdata[PINS-1:0] & ~hit)) == '0));

   // R8
   unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !mapped) |=> ($stable(dout) && $stable(dir) && $stable(mask) && $stable(mode)));

   // R9
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int unsigned PINS        = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe,
   output logic              irq_lo,
   output logic              irq_hi,
   output logic              irq_any
);

   if (PINS < 1 || PINS > BUS_W) begin : g_bad_pins
      $error("gpio_irq_port: PINS must be 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_irq_port: SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("gpio_irq_port: ADDR_W must cover offset 0x18");
   end

   logic [PINS-1:0]             lvl, hit, mask, status, pend;
   logic [PINS-1:0][TRIG_W-1:0] mode;

   gpio_irq_sync #(.W(PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .q_sync  (lvl)
   );

   gpio_irq_detect #(.PINS(PINS)) det_i (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .mode  (mode),
      .hit   (hit)
   );

   gpio_irq_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .pad       (lvl),
      .hit       (hit),
      .mode      (mode),
      .dout      (pin_out),
      .dir       (pin_oe),
      .mask      (mask),
      .status    (status)
   );

   assign pend    = status & mask;
   assign irq_any = |pend;

   if (PINS > HALF_PINS) begin : g_split
      assign irq_lo = |pend[HALF_PINS-1:0];
      assign irq_hi = |pend[PINS-1:HALF_PINS];
   end else begin : g_lower_only
      assign irq_lo = |pend;
      assign irq_hi = 1'b0;
   end

   // R7
   irq_any_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any == (irq_lo || irq_hi));

   // R7
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !(irq_lo || irq_hi));

endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;
   logic        irq_lo, irq_hi, irq_any;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   gpio_irq_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
   );

   // behavioural reference state
   bit [31:0] m_dout, m_dir, m_mask, m_stat, m_cfglo, m_cfghi, m_s1, m_s2, m_prev;

   function automatic int trig_of(int n);
      if (n < 16) return int'((m_cfglo >> (2*n)) & 32'd3);
      return int'((m_cfghi >> (2*(n-16))) & 32'd3);
   endfunction

   task automatic model_update();
      bit [31:0] ev;
      ev = '0;
      if (!rst_n) begin
         m_dout = 0; m_dir = 0; m_mask = 0; m_stat = 0;
         m_cfglo = 0; m_cfghi = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
         return;
      end
      for (int n = 0; n < 32; n++) begin
         case (trig_of(n))
            0: ev[n] = !m_s2[n];
            1: ev[n] = m_s2[n];
            2: ev[n] = m_s2[n] && !m_prev[n];
            default: ev[n] = !m_s2[n] && m_prev[n];
         endcase
      end
      if (bus_wr && bus_addr == 5'h18) m_stat = m_stat & ~bus_wdata;
      m_stat = m_stat | ev;
      if (bus_wr) begin
         case (bus_addr)
            5'h00: m_dout = bus_wdata;
            5'h04: m_dir = bus_wdata;
            5'h0C: m_cfglo = bus_wdata;
            5'h10: m_cfghi = bus_wdata;
            5'h14: m_mask = bus_wdata;
            default: ;
         endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
   endtask

   task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic compare_all();
      bit [31:0] pend, er;
      string tag;
      pend = m_stat & m_mask;
      chk("R1", "pin_out", pin_out, m_dout);
      chk("R1", "pin_oe", pin_oe, m_dir);
      chk("R7", "irq_lo", {31'd0, irq_lo}, {31'd0, |pend[15:0]});
      chk("R7", "irq_hi", {31'd0, irq_hi}, {31'd0, |pend[31:16]});
      chk("R7", "irq_any", {31'd0, irq_any}, {31'd0, |pend});
      er = 0; tag = "R9";
      if (bus_rd) begin
         case (bus_addr)
            5'h00: begin er = m_dout; tag = "R1"; end
            5'h04: begin er = m_dir; tag = "R1"; end
            5'h08: begin er = m_s2; tag = "R2"; end
            5'h0C: begin er = m_cfglo; tag = "R3"; end
            5'h10: begin er = m_cfghi; tag = "R3"; end
            5'h14: begin er = m_mask; tag = "R7"; end
            5'h18: begin er = m_stat; tag = "R6"; end
            default: begin er = 0; tag = "R8"; end
         endcase
      end
      chk(tag, "rdata(model)", bus_rdata, er);
   endtask

   // one bus cycle; optional explicit expectation on rdata
   task automatic xfer(logic [4:0] a, logic w, logic [31:0] d, logic r,
                       bit use_exp = 0, logic [31:0] exp = '0, string tag = "");
      bus_addr = a; bus_wr = w; bus_wdata = d; bus_rd = r;
      #1;
      if (rst_n) begin
         compare_all();
         if (use_exp) chk(tag, "rdata", bus_rdata, exp);
      end
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) xfer(5'h00, 1'b0, 32'h0, 1'b0);
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      xfer(a, 1'b1, d, 1'b0);
   endtask

   task automatic rd_exp(logic [4:0] a, logic [31:0] exp, string tag);
      xfer(a, 1'b0, 32'h0, 1'b1, 1, exp, tag);
   endtask

   task automatic finish_run();
      if (done) return;
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (3) xfer(5'h00, 1'b0, 32'h0, 1'b0);
      rst_n = 1'b1;
      // R8 reset state
      rd_exp(5'h18, 32'h0, "R8");
      rd_exp(5'h00, 32'h0, "R8");
      rd_exp(5'h04, 32'h0, "R8");
      rd_exp(5'h0C, 32'h0, "R8");
      rd_exp(5'h10, 32'h0, "R8");
      rd_exp(5'h14, 32'h0, "R8");
      // R4 low-level default with all pins low sets every bit; mask 0 keeps irqs off
      rd_exp(5'h18, 32'hFFFF_FFFF, "R4");
      wr(5'h14, 32'h0);
      wr(5'h18, 32'hFFFF_FFFF);
      #1; chk("R8", "irq_any after clear with mask 0", {31'd0, irq_any}, 32'd0);
      // R6 set wins while level stays active
      rd_exp(5'h18, 32'hFFFF_FFFF, "R6");
      // R1 data and direction
      wr(5'h00, 32'hA5A5_0F0F);
      wr(5'h04, 32'hFFFF_0000);
      rd_exp(5'h00, 32'hA5A5_0F0F, "R1");
      rd_exp(5'h04, 32'hFFFF_0000, "R1");
      #1; chk("R1", "pin_oe", pin_oe, 32'hFFFF_0000);
      // R2 two-cycle synchronizer
      pin_in = 32'h1234_5678;
      idle(1);
      rd_exp(5'h08, 32'h0, "R2");
      rd_exp(5'h08, 32'h1234_5678, "R2");
      wr(5'h08, 32'hDEAD_BEEF);
      rd_exp(5'h08, 32'h1234_5678, "R2");
      // R3 field placement: lower half rising, upper half falling
      pin_in = 32'hFFFF_0000;
      wr(5'h0C, 32'hAAAA_AAAA);
      wr(5'h10, 32'hFFFF_FFFF);
      rd_exp(5'h0C, 32'hAAAA_AAAA, "R3");
      rd_exp(5'h10, 32'hFFFF_FFFF, "R3");
      idle(4);
      wr(5'h18, 32'hFFFF_FFFF);
      rd_exp(5'h18, 32'h0, "R6");
      wr(5'h14, 32'hFFFF_FFFF);
      // R5 rising on pin 3
      pin_in = 32'hFFFF_0008;
      idle(4);
      rd_exp(5'h18, 32'h0000_0008, "R5");
      #1; chk("R7", "irq_lo pin3", {31'd0, irq_lo}, 32'd1);
      chk("R7", "irq_hi pin3", {31'd0, irq_hi}, 32'd0);
      // R5 falling on pin 20
      pin_in = 32'hFFEF_0008;
      idle(4);
      rd_exp(5'h18, 32'h0010_0008, "R5");
      #1; chk("R7", "irq_hi pin20", {31'd0, irq_hi}, 32'd1);
      // R5 falling on a rising pin is no event; R6 W1C
      pin_in = 32'hFFEF_0000;
      idle(4);
      wr(5'h18, 32'h0000_0008);
      rd_exp(5'h18, 32'h0010_0000, "R6");
      wr(5'h18, 32'h0);
      rd_exp(5'h18, 32'h0010_0000, "R6");
      #1; chk("R7", "irq_lo after clear", {31'd0, irq_lo}, 32'd0);
      // R4 high level on pin 5 (field bits 11:10 = 1)
      wr(5'h0C, 32'hAAAA_A6AA);
      pin_in = 32'hFFEF_0020;
      idle(4);
      rd_exp(5'h18, 32'h0010_0020, "R4");
      wr(5'h18, 32'h0000_0020);
      rd_exp(5'h18, 32'h0010_0020, "R4");
      pin_in = 32'hFFEF_0000;
      idle(4);
      wr(5'h18, 32'h0000_0020);
      rd_exp(5'h18, 32'h0010_0000, "R4");
      // R3 upper field: pin 16 low level (bits 1:0 of config-high = 0)
      wr(5'h10, 32'hFFFF_FFFC);
      pin_in = 32'hFFEE_0000;
      idle(4);
      rd_exp(5'h18, 32'h0011_0000, "R3");
      // R7 mask gates requests
      wr(5'h14, 32'h0000_FFFF);
      #1; chk("R7", "irq_hi masked", {31'd0, irq_hi}, 32'd0);
      chk("R7", "irq_any masked", {31'd0, irq_any}, 32'd0);
      // R8 unmapped offset
      wr(5'h1C, 32'hFFFF_FFFF);
      rd_exp(5'h1C, 32'h0, "R8");
      rd_exp(5'h00, 32'hA5A5_0F0F, "R8");
      rd_exp(5'h14, 32'h0000_FFFF, "R8");
      // R9 no read strobe
      xfer(5'h00, 1'b0, 32'h0, 1'b0, 1, 32'h0, "R9");
      idle(2);
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

endmodule